// File: doc/BRIEF.md
# Four-Wide Misalignment-Tolerant Instruction Fetch

This block returns up to four consecutive instruction words per fetch from an instruction store made of four narrow banks. The banks sit side by side and are read in parallel, each returning one word. Addresses are interleaved across them, so instruction word `a` lives in bank `a mod 4`, at row `a / 4`. A fetch can start at any word. When it starts partway through a row, the banks below the start bank are read one row further on. A rotation stage then puts the four bank outputs back into program order, so an unaligned fetch still yields four words in a single cycle.

The store is grouped into lines of sixteen words, which is four rows. A fetch never runs past the end of its line: a start at line offset 13, 14 or 15 returns only 3, 2 or 1 words. The unused slots are flagged invalid and driven to zero. Alongside the words, the block reports how many slots are valid and the address at which the next sequential fetch should start. All results are registered and appear one cycle after the fetch request. The store is direct-mapped with no tags, and it is filled through a single-word write port before or between fetches.

Top module: `quad_fetch`

## Requirements
- R1: Instruction word at address `a` is written through the write port into bank `a mod 4` at row `a / 4`, and a later fetch that covers `a` returns exactly that word.
- R2: A fetch whose address is a multiple of four and lies at line offset 12 or below returns four valid slots, all read from the same row.
- R3: A fetch whose start bank `k = pc mod 4` is nonzero, at line offset 12 or below, returns four valid slots: banks `k..3` are read at the current row and banks `0..k-1` at the following row.
- R4: The valid count equals `min(4, 16 - (pc mod 16))`, so line offsets 13, 14 and 15 give 3, 2 and 1, and no delivered word lies outside the line that contains `pc`.
- R5: Slot `j` (bits `[32*j+31:32*j]` of the slot bus) carries the word at address `pc + j`, so slot 0 is the word at the fetch address.
- R6: `slot_valid_o[j]` is 1 exactly when `j` is less than the valid count, and the data of every invalid slot is zero.
- R7: `next_pc_o` equals the fetch address plus the valid count, modulo the store size (64 words by default).
- R8: The results of a fetch presented at one rising edge appear after that edge with `out_valid_o` = 1. On a cycle without a fetch request, `out_valid_o` goes to 0 and the slot, mask, count and next-address outputs hold their previous values.
- R9: After a synchronous reset (`rst_n` = 0 at a clock edge), every output reads zero.
- R10: Summed over the 16 start offsets of one line, the valid counts total 58, an average of 3.625 words per fetch.
- R11: A write in the same cycle as a fetch that reads the same address does not change that fetch's result, and the new word is returned by the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch request this cycle |
| fetch_pc_i | input | 6 | Fetch start address in words |
| wr_en_i | input | 1 | Store write enable |
| wr_addr_i | input | 6 | Store write address in words |
| wr_data_i | input | 32 | Store write data |
| out_valid_o | output | 1 | Registered fetch results are new this cycle |
| slot_data_o | output | 128 | Four slots in program order, slot j at bits [32*j+31:32*j] |
| slot_valid_o | output | 4 | Per-slot valid flags |
| slot_count_o | output | 3 | Number of valid slots, 1 to 4 |
| next_pc_o | output | 6 | Fetch address plus valid count |

## Verification
The assertions assume that `fetch_pc_i` and `fetch_valid_i` are driven to known values from the first clock edge. They also assume that `fetch_valid_i` stays low during reset, because the latency and hold properties compare against the cycle before. The bench drives every input at the falling edge and holds the request low until reset is released. It preloads every word through the write port before it fetches anything, so bank reads never return undefined contents. Fetch addresses cover aligned starts, every misaligned bank position, the three line-end offsets and the wrap at the top of the store.

// File: rtl/quad_fetch_pkg.sv
// Shared constants for the four-bank fetch block.
// Assumes a fixed four-bank interleave; widths for addresses come from
// parameters of the modules that use these constants.
package quad_fetch_pkg;
    localparam int SUBS  = 4;  // banks read in parallel
    localparam int SUB_W = 2;  // bits selecting a bank
    localparam int CNT_W = 3;  // width of a 0..4 slot count
endpackage

// File: rtl/qf_bank.sv
// One bank of the instruction store plus its row-select logic.
// Holds every fourth word. Banks below the start bank read the next row;
// the topmost bank never needs that and has no incrementer.
// Assumes writes are pre-qualified by the caller for this bank.
module qf_bank
    import quad_fetch_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int SUB_ROWS = 16,
    parameter int IDX      = 0,
    localparam int ROW_W   = $clog2(SUB_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ROW_W-1:0]  wr_row_i,
    input  logic [INSN_W-1:0] wr_data_i,
    input  logic [ROW_W-1:0]  base_row_i,
    input  logic [SUB_W-1:0]  start_sub_i,
    output logic [INSN_W-1:0] rd_data_o
);
    logic [INSN_W-1:0] mem [SUB_ROWS];
    logic [ROW_W-1:0]  row;

    // Preload write port: one word per cycle into this bank.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_row_i] <= wr_data_i;
    end

    generate
        if (IDX < SUBS - 1) begin : g_inc
            // Step to the next row when this bank precedes the start bank.
            always_comb row = base_row_i + ROW_W'(SUB_W'(IDX) < start_sub_i);

            // R3
            next_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (SUB_W'(IDX) < start_sub_i) |-> (row != base_row_i));
        end else begin : g_flat
            // Topmost bank always reads the current row.
            always_comb row = base_row_i;
        end
    endgenerate

    // Asynchronous read of the selected row.
    always_comb rd_data_o = mem[row];

    // R2
    cur_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SUB_W'(IDX) >= start_sub_i) |-> (row == base_row_i));
endmodule

// File: rtl/qf_count.sv
// Slot count, per-slot valid mask and next fetch address.
// Clips the group at the end of the line that holds the start address.
// Assumes line length is a power of two no smaller than four words.
module qf_count
    import quad_fetch_pkg::*;
#(
    parameter int PC_W      = 6,
    parameter int LINE_ROWS = 4,
    localparam int LINE_INSNS = LINE_ROWS * SUBS,
    localparam int OFF_W      = $clog2(LINE_INSNS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc_i,
    output logic [CNT_W-1:0] count_o,
    output logic [SUBS-1:0]  mask_o,
    output logic [PC_W-1:0]  next_pc_o
);
    logic [OFF_W-1:0] offset;
    logic [OFF_W:0]   remaining;

    // Words left in the line from the start offset.
    always_comb begin
        offset    = pc_i[OFF_W-1:0];
        remaining = (OFF_W+1)'(LINE_INSNS) - {1'b0, offset};
        count_o   = (remaining >= (OFF_W+1)'(SUBS)) ? CNT_W'(SUBS)
                                                    : CNT_W'(remaining);
        next_pc_o = pc_i + PC_W'(count_o);
    end

    generate
        for (genvar j = 0; j < SUBS; j++) begin : g_mask
            // Slot j is valid while its word stays inside the line.
            assign mask_o[j] = ({1'b0, offset} + (OFF_W+1)'(j)) < (OFF_W+1)'(LINE_INSNS);
        end
    endgenerate

    // R6
    mask_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask_o) == int'(count_o));
endmodule

// File: rtl/qf_rotator.sv
// Rotates the four bank outputs into program order and zeroes invalid slots.
// Assumes bank k holds word addresses congruent to k modulo four.
module qf_rotator
    import quad_fetch_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0]      bank_data_i [SUBS],
    input  logic [SUB_W-1:0]       start_sub_i,
    input  logic [SUBS-1:0]        mask_i,
    output logic [SUBS*INSN_W-1:0] slot_data_o
);
    generate
        for (genvar j = 0; j < SUBS; j++) begin : g_slot
            logic [SUB_W-1:0] src;
            // Slot j takes the bank j places after the start bank.
            always_comb begin
                src = start_sub_i + SUB_W'(j);
                slot_data_o[j*INSN_W +: INSN_W] = mask_i[j] ? bank_data_i[src] : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/quad_fetch.sv
// Four-wide fetch over a four-bank interleaved instruction store.
// Reads all banks in parallel, corrects rows for unaligned starts,
// rotates into program order, and registers the result (one cycle).
// Assumes fetch_valid_i is low during reset and inputs are never X.
module quad_fetch
    import quad_fetch_pkg::*;
#(
    parameter int INSN_W    = 32,
    parameter int SUB_ROWS  = 16,
    parameter int LINE_ROWS = 4,
    localparam int PC_W     = $clog2(SUB_ROWS * SUBS),
    localparam int ROW_W    = $clog2(SUB_ROWS),
    localparam int OFF_W    = $clog2(LINE_ROWS * SUBS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_valid_i,
    input  logic [PC_W-1:0]        fetch_pc_i,
    input  logic                   wr_en_i,
    input  logic [PC_W-1:0]        wr_addr_i,
    input  logic [INSN_W-1:0]      wr_data_i,
    output logic                   out_valid_o,
    output logic [SUBS*INSN_W-1:0] slot_data_o,
    output logic [SUBS-1:0]        slot_valid_o,
    output logic [CNT_W-1:0]       slot_count_o,
    output logic [PC_W-1:0]        next_pc_o
);
    logic [INSN_W-1:0]      bank_data [SUBS];
    logic [SUBS*INSN_W-1:0] rot_data;
    logic [CNT_W-1:0]       cnt;
    logic [SUBS-1:0]        mask;
    logic [PC_W-1:0]        nxt_pc;
    logic [SUB_W-1:0]       start_sub;
    logic [ROW_W-1:0]       base_row;

    // Split the fetch address into start bank and base row.
    always_comb begin
        start_sub = fetch_pc_i[SUB_W-1:0];
        base_row  = fetch_pc_i[PC_W-1:SUB_W];
    end

    generate
        for (genvar k = 0; k < SUBS; k++) begin : g_bank
            qf_bank #(.INSN_W(INSN_W), .SUB_ROWS(SUB_ROWS), .IDX(k)) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en_i    (wr_en_i && (wr_addr_i[SUB_W-1:0] == SUB_W'(k))),
                .wr_row_i   (wr_addr_i[PC_W-1:SUB_W]),
                .wr_data_i  (wr_data_i),
                .base_row_i (base_row),
                .start_sub_i(start_sub),
                .rd_data_o  (bank_data[k])
            );
        end
    endgenerate

    qf_count #(.PC_W(PC_W), .LINE_ROWS(LINE_ROWS)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_i     (fetch_pc_i),
        .count_o  (cnt),
        .mask_o   (mask),
        .next_pc_o(nxt_pc)
    );

    qf_rotator #(.INSN_W(INSN_W)) u_rot (
        .bank_data_i(bank_data),
        .start_sub_i(start_sub),
        .mask_i     (mask),
        .slot_data_o(rot_data)
    );

    // Output register: load on a fetch, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o  <= 1'b0;
            slot_data_o  <= '0;
            slot_valid_o <= '0;
            slot_count_o <= '0;
            next_pc_o    <= '0;
        end else begin
            out_valid_o <= fetch_valid_i;
            if (fetch_valid_i) begin
                slot_data_o  <= rot_data;
                slot_valid_o <= mask;
                slot_count_o <= cnt;
                next_pc_o    <= nxt_pc;
            end
        end
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> out_valid_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_i |=> (!out_valid_o && $stable(slot_data_o) && $stable(next_pc_o)));

    // R7
    next_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> (next_pc_o == $past(fetch_pc_i) + PC_W'(slot_count_o)));

    // R4
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_i |=> ((next_pc_o[OFF_W-1:0] == '0) ||
                           (next_pc_o[PC_W-1:OFF_W] == $past(fetch_pc_i[PC_W-1:OFF_W]))));

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((slot_count_o != '0) && (slot_count_o <= CNT_W'(SUBS)) &&
                         ($countones(slot_valid_o) == int'(slot_count_o))));
endmodule

// File: tb/quad_fetch_bench.sv
module quad_fetch_bench;
    localparam int W  = 32;
    localparam int PW = 6;
    localparam int N  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid_i = 1'b0;
    logic [PW-1:0] fetch_pc_i = '0;
    logic          wr_en_i = 1'b0;
    logic [PW-1:0] wr_addr_i = '0;
    logic [W-1:0]  wr_data_i = '0;
    logic          out_valid_o;
    logic [4*W-1:0] slot_data_o;
    logic [3:0]    slot_valid_o;
    logic [2:0]    slot_count_o;
    logic [PW-1:0] next_pc_o;

    logic [W-1:0] model [N];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    quad_fetch u_quad_fetch (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .out_valid_o(out_valid_o), .slot_data_o(slot_data_o), .slot_valid_o(slot_valid_o),
        .slot_count_o(slot_count_o), .next_pc_o(next_pc_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input int pc);
        int rem = 16 - (pc % 16);
        return (rem > 4) ? 4 : rem;
    endfunction

    // Issue one fetch; returns at the falling edge after the result is registered.
    task automatic do_fetch(input int pc);
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_pc_i    = PW'(pc);
        @(negedge clk);
        fetch_valid_i = 1'b0;
    endtask

    // Compare every output against the model for a fetch at pc.
    task automatic verify(input string req, input int pc);
        int c = exp_count(pc);
        check({req, " out_valid"}, 64'(out_valid_o), 64'(1));
        check({req, " R4 count"}, 64'(slot_count_o), 64'(c));
        check({req, " R6 mask"}, 64'(slot_valid_o), 64'((1 << c) - 1));
        for (int j = 0; j < 4; j++) begin
            logic [W-1:0] e = (j < c) ? model[(pc + j) % N] : '0;
            check({req, " R5 slot"}, 64'(slot_data_o[j*W +: W]), 64'(e));
        end
        check({req, " R7 next_pc"}, 64'(next_pc_o), 64'((pc + c) % N));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 out_valid", 64'(out_valid_o), 0);
        check("R9 slot_data", 64'(slot_data_o[63:0] | slot_data_o[127:64]), 0);
        check("R9 slot_valid", 64'(slot_valid_o), 0);
        check("R9 count", 64'(slot_count_o), 0);
        check("R9 next_pc", 64'(next_pc_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_preload();  // R1
        for (int a = 0; a < N; a++) begin
            @(negedge clk);
            wr_en_i   = 1'b1;
            wr_addr_i = PW'(a);
            wr_data_i = 32'hC0DE_0000 + W'(a * 257);
            model[a]  = 32'hC0DE_0000 + W'(a * 257);
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic t_aligned();  // R2, R1
        int pcs[5] = '{0, 4, 8, 28, 44};
        foreach (pcs[i]) begin
            do_fetch(pcs[i]);
            verify("R2 aligned", pcs[i]);
        end
    endtask

    task automatic t_misaligned();  // R3
        int pcs[7] = '{1, 2, 3, 6, 11, 33, 58};
        foreach (pcs[i]) begin
            do_fetch(pcs[i]);
            verify("R3 misaligned", pcs[i]);
        end
    endtask

    task automatic t_line_end();  // R4, R6, R7 wrap at 63
        int pcs[6] = '{13, 14, 15, 29, 46, 63};
        foreach (pcs[i]) begin
            do_fetch(pcs[i]);
            verify("R4 line end", pcs[i]);
        end
    endtask

    task automatic t_average();  // R10
        int sum = 0;
        for (int off = 0; off < 16; off++) begin
            do_fetch(32 + off);
            sum += int'(slot_count_o);
        end
        check("R10 count sum", 64'(sum), 64'(58));
    endtask

    task automatic t_idle_hold();  // R8
        logic [4*W-1:0] held;
        do_fetch(21);
        verify("R8 latency", 21);
        held = slot_data_o;
        repeat (2) @(negedge clk);
        check("R8 idle out_valid", 64'(out_valid_o), 0);
        check("R8 idle data", 64'(slot_data_o[63:0] ^ held[63:0]), 0);
        check("R8 idle count", 64'(slot_count_o), 64'(4));
        check("R8 idle next_pc", 64'(next_pc_o), 64'(25));
    endtask

    task automatic t_write_during_fetch();  // R11
        @(negedge clk);
        fetch_valid_i = 1'b1;
        fetch_pc_i    = PW'(9);
        wr_en_i       = 1'b1;
        wr_addr_i     = PW'(10);
        wr_data_i     = 32'hFEED_0A0A;
        @(negedge clk);
        fetch_valid_i = 1'b0;
        wr_en_i       = 1'b0;
        verify("R11 old word", 9);
        model[10] = 32'hFEED_0A0A;
        do_fetch(9);
        verify("R11 new word", 9);
        check("R11 slot1", 64'(slot_data_o[W +: W]), 64'(32'hFEED_0A0A));
    endtask

    initial begin
        t_reset();
        t_preload();
        t_aligned();
        t_misaligned();
        t_line_end();
        t_average();
        t_idle_hold();
        t_write_during_fetch();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule